// File: doc/BRIEF.md
# Hashed Inverted Frame Table

This block holds a single system-wide translation table with one slot for every physical frame. Each slot records which process owns the frame and which virtual page that process has mapped there. Software-visible frame numbers are never stored: the position of a slot is its frame number. A lookup presents a (process id, virtual page) pair and receives either the frame that holds it or a miss.

A hash of the pair picks one of a set of buckets. A small bucket-head array holds the first frame of each bucket's chain. Each slot carries a link to the next frame of the same chain, so colliding pairs form a linked list threaded through the table itself. A lookup walks that list at one slot per clock. An insert pushes a frame onto the front of its chain in one cycle. A remove, addressed by frame number, walks the chain to find the predecessor and unlinks the slot. `req_ready` is low while a walk is in progress. A walk that visits as many slots as there are frames without reaching the end is reported as an error, which guards against a corrupted, looping chain.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and the table is empty, so every lookup misses.
- R2: The bucket of a pair is formed from key = vpn XOR (pid shifted left by PID_SHIFT, truncated to VPN_W bits). The key is cut into BKT_W-bit slices starting at bit 0, and the slices are XORed together.
- R3: The request is accepted on the edge where `req_valid` and `req_ready` are both 1. Call that edge 0. An insert (`req_op` = 1) updates the table on edge 0, and its response (`rsp_hit`=1, `rsp_err`=0, `rsp_frame`=`req_frame`) is valid after edge 0. The inserted frame becomes the head of its bucket's chain.
- R4: A lookup (`req_op` = 0) whose pair is held by the entry at chain position p (the head is p=0) responds after edge p+1 with `rsp_hit`=1 and `rsp_frame` set to that entry's frame.
- R5: A lookup whose pair is absent, in a bucket with a chain of length L, responds after edge L+1 with `rsp_hit`=0, `rsp_err`=0 and `rsp_frame`=0.
- R6: `req_ready` stays 0 from the acceptance of a chain walk until the cycle in which its response is valid. A request presented while `req_ready` is 0 has no effect.
- R7: A remove (`req_op` = 2) of a valid frame at the head of its chain responds after edge 0 with `rsp_hit`=1. The frame is then unlinked, and a lookup of its pair misses.
- R8: A remove of a valid frame at chain position p>0 responds after edge p with `rsp_hit`=1. The other entries of the chain keep their order.
- R9: A remove of a frame that is not valid responds after edge 0 with `rsp_hit`=0 and `rsp_err`=0, and leaves the table unchanged.
- R10: A lookup that has examined N_FRAMES entries without a match or a chain end responds after edge N_FRAMES+1 with `rsp_err`=1, `rsp_hit`=0 and `rsp_frame`=0.
- R11: Op code 3 is accepted but does nothing: no response follows and the table is unchanged.
- R12: `rsp_valid` is a one-cycle pulse. It is only 1 while `req_ready` is 1, and `rsp_hit` and `rsp_err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 lookup, 1 insert, 2 remove, 3 no operation |
| req_pid | input | PID_W | Process id of the pair |
| req_vpn | input | VPN_W | Virtual page number of the pair |
| req_frame | input | log2(N_FRAMES) | Frame for insert or remove |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Lookup found / insert done / remove found |
| rsp_err | output | 1 | Walk exceeded the frame count or lost its target |
| rsp_frame | output | log2(N_FRAMES) | Frame of a hit, or the frame of an insert or remove |

## Verification
The bench builds chains of four colliding pairs in one bucket. It then checks that every position answers at its own latency, so a design that started at the wrong bucket, or that appended at the tail instead of the head, would return wrong frames or wrong latencies. Removes at the head, in the middle and at the tail are followed by lookups. A broken unlink would either leave a stale hit or cut off the entries behind the removed one. A request held high during a walk is checked to have no effect, which catches a design that accepts while busy. A deliberately self-linked frame is used to make sure the walk ends with an error after exactly N_FRAMES+1 edges, instead of hanging or reporting a miss.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    OP_LOOK = 2'd0,
    OP_INS  = 2'd1,
    OP_REM  = 2'd2,
    OP_NOP  = 2'd3
  } ipt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_UNLK = 2'd2
  } ipt_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W     = 4,
  parameter int VPN_W     = 12,
  parameter int BKT_W     = 3,
  parameter int PID_SHIFT = 2
) (
  input  logic [PID_W-1:0] pid,
  input  logic [VPN_W-1:0] vpn,
  output logic [BKT_W-1:0] bkt
);
  function automatic logic [BKT_W-1:0] fold(input logic [VPN_W-1:0] key);
    logic [BKT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < VPN_W; i++) acc[i % BKT_W] ^= key[i];
    return acc;
  endfunction

  logic [VPN_W-1:0] key;
  assign key = vpn ^ (VPN_W'(pid) << PID_SHIFT);
  assign bkt = fold(key);
endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int N_FRAMES  = 16,
  parameter int N_BUCKETS = 8,
  parameter int PID_W     = 4,
  parameter int VPN_W     = 12,
  localparam int FW = $clog2(N_FRAMES),
  localparam int BW = $clog2(N_BUCKETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  // full entry write (marks valid)
  input  logic             ent_we,
  input  logic [FW-1:0]    ent_idx,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic             ent_nv,
  input  logic [FW-1:0]    ent_nx,
  // link rewrite
  input  logic             lnk_we,
  input  logic [FW-1:0]    lnk_idx,
  input  logic             lnk_nv,
  input  logic [FW-1:0]    lnk_nx,
  // invalidate
  input  logic             clr_we,
  input  logic [FW-1:0]    clr_idx,
  // bucket head write
  input  logic             hd_we,
  input  logic [BW-1:0]    hd_b,
  input  logic             hd_v,
  input  logic [FW-1:0]    hd_x,
  // read port A: whole entry
  input  logic [FW-1:0]    pa_idx,
  output logic             pa_v,
  output logic [PID_W-1:0] pa_pid,
  output logic [VPN_W-1:0] pa_vpn,
  output logic             pa_nv,
  output logic [FW-1:0]    pa_nx,
  // read port B: link only
  input  logic [FW-1:0]    pb_idx,
  output logic             pb_nv,
  output logic [FW-1:0]    pb_nx,
  // head read
  input  logic [BW-1:0]    hr_b,
  output logic             hr_v,
  output logic [FW-1:0]    hr_x
);
  logic             v_q   [N_FRAMES];
  logic [PID_W-1:0] pid_q [N_FRAMES];
  logic [VPN_W-1:0] vpn_q [N_FRAMES];
  logic             nv_q  [N_FRAMES];
  logic [FW-1:0]    nx_q  [N_FRAMES];
  logic             hv_q  [N_BUCKETS];
  logic [FW-1:0]    hx_q  [N_BUCKETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_FRAMES; i++) begin
        v_q[i]   <= 1'b0;
        pid_q[i] <= '0;
        vpn_q[i] <= '0;
        nv_q[i]  <= 1'b0;
        nx_q[i]  <= '0;
      end
      for (int b = 0; b < N_BUCKETS; b++) begin
        hv_q[b] <= 1'b0;
        hx_q[b] <= '0;
      end
    end else begin
      if (ent_we) begin
        v_q[ent_idx]   <= 1'b1;
        pid_q[ent_idx] <= ent_pid;
        vpn_q[ent_idx] <= ent_vpn;
        nv_q[ent_idx]  <= ent_nv;
        nx_q[ent_idx]  <= ent_nx;
      end
      if (lnk_we) begin
        nv_q[lnk_idx] <= lnk_nv;
        nx_q[lnk_idx] <= lnk_nx;
      end
      if (clr_we) v_q[clr_idx] <= 1'b0;
      if (hd_we) begin
        hv_q[hd_b] <= hd_v;
        hx_q[hd_b] <= hd_x;
      end
    end
  end

  assign pa_v   = v_q[pa_idx];
  assign pa_pid = pid_q[pa_idx];
  assign pa_vpn = vpn_q[pa_idx];
  assign pa_nv  = nv_q[pa_idx];
  assign pa_nx  = nx_q[pa_idx];
  assign pb_nv  = nv_q[pb_idx];
  assign pb_nx  = nx_q[pb_idx];
  assign hr_v   = hv_q[hr_b];
  assign hr_x   = hx_q[hr_b];
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
  import ipt_pkg::*;
#(
  parameter int N_FRAMES  = 16,
  parameter int N_BUCKETS = 8,
  parameter int PID_W     = 4,
  parameter int VPN_W     = 12,
  parameter int PID_SHIFT = 2,
  localparam int FW = $clog2(N_FRAMES),
  localparam int BW = $clog2(N_BUCKETS),
  localparam int SW = $clog2(N_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [FW-1:0]    req_frame,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_err,
  output logic [FW-1:0]    rsp_frame
);
  ipt_st_e          st;
  logic [FW-1:0]    cur, tgt;
  logic             cur_v;
  logic [SW-1:0]    steps;
  logic [PID_W-1:0] key_pid;
  logic [VPN_W-1:0] key_vpn;

  // store ports
  logic             ent_we, lnk_we, clr_we, hd_we;
  logic [FW-1:0]    ent_idx, lnk_idx, clr_idx, hd_x, ent_nx, lnk_nx;
  logic             ent_nv, lnk_nv, hd_v;
  logic [BW-1:0]    hd_b, hr_b;
  logic [FW-1:0]    pa_idx, pa_nx, pb_nx, hr_x;
  logic             pa_v, pa_nv, pb_nv, hr_v;
  logic [PID_W-1:0] pa_pid;
  logic [VPN_W-1:0] pa_vpn;
  logic [BW-1:0]    req_bkt, ent_bkt;

  // named events for the checker
  logic accept, walk_busy, at_end, over_limit, key_match, pred_found;

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .BKT_W(BW), .PID_SHIFT(PID_SHIFT))
    u_hreq (.pid(req_pid), .vpn(req_vpn), .bkt(req_bkt));
  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .BKT_W(BW), .PID_SHIFT(PID_SHIFT))
    u_hent (.pid(pa_pid), .vpn(pa_vpn), .bkt(ent_bkt));

  ipt_store #(.N_FRAMES(N_FRAMES), .N_BUCKETS(N_BUCKETS), .PID_W(PID_W), .VPN_W(VPN_W))
    u_store (
      .clk(clk), .rst_n(rst_n),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_pid(req_pid), .ent_vpn(req_vpn),
      .ent_nv(ent_nv), .ent_nx(ent_nx),
      .lnk_we(lnk_we), .lnk_idx(lnk_idx), .lnk_nv(lnk_nv), .lnk_nx(lnk_nx),
      .clr_we(clr_we), .clr_idx(clr_idx),
      .hd_we(hd_we), .hd_b(hd_b), .hd_v(hd_v), .hd_x(hd_x),
      .pa_idx(pa_idx), .pa_v(pa_v), .pa_pid(pa_pid), .pa_vpn(pa_vpn),
      .pa_nv(pa_nv), .pa_nx(pa_nx),
      .pb_idx(tgt), .pb_nv(pb_nv), .pb_nx(pb_nx),
      .hr_b(hr_b), .hr_v(hr_v), .hr_x(hr_x)
    );

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign walk_busy  = (st != ST_IDLE);
  assign at_end     = !cur_v;
  assign over_limit = (steps == SW'(N_FRAMES));
  assign key_match  = pa_v && (pa_pid == key_pid) && (pa_vpn == key_vpn);
  assign pred_found = pa_nv && (pa_nx == tgt);
  assign pa_idx     = (st == ST_IDLE) ? req_frame : cur;
  assign hr_b       = (req_op == OP_REM) ? ent_bkt : req_bkt;

  always_comb begin
    ent_we = 1'b0; ent_idx = req_frame; ent_nv = hr_v; ent_nx = hr_x;
    lnk_we = 1'b0; lnk_idx = cur; lnk_nv = pb_nv; lnk_nx = pb_nx;
    clr_we = 1'b0; clr_idx = req_frame;
    hd_we  = 1'b0; hd_b = req_bkt; hd_v = 1'b1; hd_x = req_frame;
    if (accept && req_op == OP_INS) begin
      ent_we = 1'b1;
      hd_we  = 1'b1;
    end else if (accept && req_op == OP_REM && pa_v && hr_v && hr_x == req_frame) begin
      hd_we  = 1'b1; hd_b = ent_bkt; hd_v = pa_nv; hd_x = pa_nx;
      clr_we = 1'b1;
    end else if (st == ST_UNLK && !at_end && !over_limit && pred_found) begin
      lnk_we  = 1'b1;
      clr_we  = 1'b1;
      clr_idx = tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cur <= '0; cur_v <= 1'b0; tgt <= '0; steps <= '0;
      key_pid <= '0; key_vpn <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_err <= 1'b0; rsp_frame <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          unique case (req_op)
            OP_LOOK: begin
              key_pid <= req_pid; key_vpn <= req_vpn;
              cur <= hr_x; cur_v <= hr_v; steps <= '0;
              st <= ST_LOOK;
            end
            OP_INS: begin
              rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_err <= 1'b0; rsp_frame <= req_frame;
            end
            OP_REM: begin
              tgt <= req_frame;
              if (!pa_v || (hr_v && hr_x == req_frame)) begin
                rsp_valid <= 1'b1; rsp_hit <= pa_v; rsp_err <= 1'b0; rsp_frame <= req_frame;
              end else begin
                cur <= hr_x; cur_v <= hr_v; steps <= '0;
                st <= ST_UNLK;
              end
            end
            default: ;
          endcase
        end
        ST_LOOK: begin
          if (at_end || over_limit) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b0; rsp_err <= !at_end; rsp_frame <= '0;
            st <= ST_IDLE;
          end else if (key_match) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_err <= 1'b0; rsp_frame <= cur;
            st <= ST_IDLE;
          end else begin
            cur <= pa_nx; cur_v <= pa_nv; steps <= steps + 1'b1;
          end
        end
        ST_UNLK: begin
          if (at_end || over_limit) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b0; rsp_err <= 1'b1; rsp_frame <= tgt;
            st <= ST_IDLE;
          end else if (pred_found) begin
            rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_err <= 1'b0; rsp_frame <= tgt;
            st <= ST_IDLE;
          end else begin
            cur <= pa_nx; cur_v <= pa_nv; steps <= steps + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int N_FRAMES = 16,
  localparam int FW = $clog2(N_FRAMES),
  localparam int CW = $clog2(N_FRAMES + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [FW-1:0] req_frame,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_err,
  input logic [FW-1:0] rsp_frame,
  input logic          walk_busy
);
  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (walk_busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  // R3
  insert_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd1) |=>
      (rsp_valid && rsp_hit && !rsp_err && rsp_frame == $past(req_frame)));

  // R6
  walk_holds_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> !req_ready);

  // R10
  walk_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> (busy_cnt <= CW'(N_FRAMES)));

  // R11
  nop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd3) |=> (!rsp_valid && req_ready));

  // R12
  rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R12
  hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_err));

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_valid) |=> !rsp_valid);
endmodule

bind ipt_lookup ipt_lookup_chk #(.N_FRAMES(N_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_frame(req_frame), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_frame(rsp_frame),
  .walk_busy(walk_busy)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int NB = 8;
  localparam int PW = 4;
  localparam int VW = 12;
  localparam int SH = 2;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [PW-1:0] req_pid = '0;
  logic [VW-1:0] req_vpn = '0;
  logic [FW-1:0] req_frame = '0;
  logic rsp_valid, rsp_hit, rsp_err;
  logic [FW-1:0] rsp_frame;

  int total = 0;
  int bad = 0;
  bit expect_rsp = 1'b0;

  // behavioural model
  bit mv [N];
  int mp [N];
  int mvpn [N];
  int chain [NB][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipt_lookup #(.N_FRAMES(N), .N_BUCKETS(NB), .PID_W(PW), .VPN_W(VW), .PID_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_pid(req_pid), .req_vpn(req_vpn), .req_frame(req_frame),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_frame(rsp_frame)
  );

  function automatic int bucket_of(int pid, int vpn);
    int x, b;
    x = (vpn ^ (pid << SH)) & ((1 << VW) - 1);
    b = 0;
    while (x != 0) begin
      b = b ^ (x & (NB - 1));
      x = x >> 3;
    end
    return b;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // every clock: no response outside an operation window (R12)
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !expect_rsp) begin
      total++; bad++;
      $display("FAIL R12 spurious response actual=1 expected=0");
    end
  end

  task automatic do_op(int op, int pid, int vpn, int frm, int e_lat, int e_hit,
                       int e_err, int e_frm, bit junk, string tag);
    int lat;
    bit busy_ok;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_pid = PW'(pid);
    req_vpn = VW'(vpn); req_frame = FW'(frm);
    expect_rsp = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    busy_ok = 1'b1;
    while (!rsp_valid && lat < 40) begin
      if (req_ready) busy_ok = 1'b0;
      if (junk) begin
        req_valid = 1'b1; req_op = 2'd1; req_frame = FW'(N - 1);
      end
      @(posedge clk); #1;
      lat++;
    end
    req_valid = 1'b0;
    chk("R6", {tag, " ready low while walking"}, busy_ok, 1);
    chk(tag, "latency", lat, e_lat);
    chk(tag, "hit", rsp_hit, e_hit);
    chk(tag, "err", rsp_err, e_err);
    if (e_frm >= 0) chk(tag, "frame", rsp_frame, e_frm);
    chk("R12", "ready with response", req_ready, 1);
    @(posedge clk); #1;
    chk("R12", "single-cycle pulse", rsp_valid, 0);
    expect_rsp = 1'b0;
  endtask

  task automatic m_insert(int pid, int vpn, int f, string tag);
    int b;
    b = bucket_of(pid, vpn);
    do_op(1, pid, vpn, f, 0, 1, 0, f, 1'b0, tag);
    mv[f] = 1'b1; mp[f] = pid; mvpn[f] = vpn;
    chain[b].push_front(f);
  endtask

  task automatic m_lookup(int pid, int vpn, string tag, bit junk = 1'b0);
    int b, pos, fr;
    b = bucket_of(pid, vpn);
    pos = -1; fr = 0;
    foreach (chain[b][i]) begin
      if (pos < 0 && mv[chain[b][i]] && mp[chain[b][i]] == pid && mvpn[chain[b][i]] == vpn) begin
        pos = i; fr = chain[b][i];
      end
    end
    if (pos >= 0) do_op(0, pid, vpn, 0, pos + 1, 1, 0, fr, junk, tag);
    else do_op(0, pid, vpn, 0, chain[b].size() + 1, 0, 0, 0, junk, tag);
  endtask

  task automatic m_remove(int f, string tag);
    int b, pos;
    if (!mv[f]) begin
      do_op(2, 0, 0, f, 0, 0, 0, f, 1'b0, tag);
    end else begin
      b = bucket_of(mp[f], mvpn[f]);
      pos = 0;
      foreach (chain[b][i]) if (chain[b][i] == f) pos = i;
      do_op(2, 0, 0, f, pos, 1, 0, f, 1'b0, tag);
      chain[b].delete(pos);
      mv[f] = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    base = 'h123;
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    m_lookup(5, base, "R1");

    // four colliding pairs (R2: bits i and i+3 cancel in the fold)
    m_insert(5, base,      2,  "R3");
    m_insert(5, base ^ 9,  7,  "R3");
    m_insert(5, base ^ 18, 11, "R3");
    m_insert(5, base ^ 27, 4,  "R3");
    m_lookup(5, base ^ 27, "R4");
    m_lookup(5, base ^ 18, "R4");
    m_lookup(5, base ^ 9,  "R4");
    m_lookup(5, base,      "R2");
    m_lookup(5, base ^ 36, "R5");

    // other pid, same page: separate key and bucket
    m_insert(6, base, 9, "R3");
    m_lookup(6, base, "R2");
    m_lookup(6, base ^ 9, "R5");
    m_lookup(5, base, "R4");

    // removes
    m_remove(7, "R8");
    m_lookup(5, base, "R8");
    m_lookup(5, base ^ 18, "R8");
    m_remove(4, "R7");
    m_lookup(5, base ^ 27, "R7");
    m_remove(4, "R9");
    m_lookup(5, base ^ 18, "R9");

    // request held high during a walk has no effect
    m_lookup(5, base, "R6", 1'b1);
    m_remove(N - 1, "R6");
    m_remove(2, "R8");
    m_lookup(5, base, "R5");

    // no-op code
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_frame = 4'd1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R11", "no response to op 3", rsp_valid, 0);
    end
    m_remove(1, "R11");
    m_lookup(5, base ^ 18, "R11");

    // corrupted loop: same frame inserted twice links to itself
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_op(1, 1, 'h040, 3, 0, 1, 0, 3, 1'b0, "R3");
    do_op(1, 1, 'h040, 3, 0, 1, 0, 3, 1'b0, "R3");
    do_op(0, 1, 'h040 ^ 9, 0, N + 1, 0, 1, 0, 1'b0, "R10");
    do_op(0, 1, 'h040, 0, 1, 1, 0, 3, 1'b0, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule